// File: doc/BRIEF.md
# Line Interface Mode Controller

This block holds the digital control and status logic of a subscriber line interface. The line card controller picks the operating mode with two inputs, a standby select and a ring request. Two raw detector bits, one for loop current (hook) and one for ground key, come in as synchronous digital levels. Each detector bit goes through its own debounce filter with a programmable terminal count. The block returns four registered outputs: an active-low hook status, an active-low ground-key status, an active-low codec power-up, and an enable for the ringing injector.

The decoded mode sets how the filtered detections reach the outputs. With standby low and ring low the line is active. With standby low and ring high the line is ringing. With standby high the line is in stand-by. While ringing, any filtered detection is treated as ring trip. It removes the injector enable at once and holds it removed until the ring request goes low again. A ground key pulls the hook status low as well as the ground-key status. In stand-by the detector filters are held clear, so no detection is reported.

Top module: `line_mode_ctrl`

## Requirements
- R1: While the asynchronous reset is asserted, the outputs read hookStatN=1, gndKeyStatN=1, codecPuN=1, ringEn=0, and the ring-trip latch is clear.
- R2: standbyIn and ringReqIn each pass through two synchronizing flops before the registered outputs. A mode change driven before a clock edge reaches the outputs on the third rising edge.
- R3: In active mode (standby=0, ring=0) with no filtered detection, the outputs are hookStatN=1, gndKeyStatN=1, codecPuN=1, ringEn=0.
- R4: In active mode, a filtered off-hook with no ground key gives hookStatN=0, gndKeyStatN=1, codecPuN=0, ringEn=0.
- R5: In active or ringing mode, a filtered ground key drives hookStatN=0, gndKeyStatN=0 and codecPuN=0, whatever the hook detector reads.
- R6: In ringing mode (standby=0, ring=1) with no detection and the trip latch clear, the outputs are hookStatN=1, gndKeyStatN=1, codecPuN=0, ringEn=1.
- R7: In ringing mode, any filtered detection sets the trip latch and clears ringEn. ringEn stays 0 after the detection goes away, until the synchronized ring request returns to 0.
- R8: In stand-by (standby=1), the detector inputs have no effect and hookStatN=gndKeyStatN=1. With ring=0 the block gives codecPuN=1 and ringEn=0. With ring=1 it gives codecPuN=0 and ringEn=1.
- R9: Each filter is a saturating up/down counter. It counts up while its raw bit is 1 and down while the bit is 0. The filtered bit sets when the count reaches the terminal count and clears when the count reaches 0, so a pulse shorter than the terminal count is ignored. A raw level held from before an edge shows on the status output at the rising edge that follows the terminal-count edge.
- R10: The hook filter uses hookLimit as its terminal count and the ground-key filter uses gndKeyLimit, each set independently.
- R11: In stand-by both filter counters and both filtered bits are held at zero. After stand-by is left, a raw level that is still held needs the full terminal count again before it is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| standbyIn | input | 1 | Stand-by select from the line card controller |
| ringReqIn | input | 1 | Ring request from the line card controller |
| hookRaw | input | 1 | Raw loop-current detector bit, synchronous |
| gndKeyRaw | input | 1 | Raw ground-key detector bit, synchronous |
| hookLimit | input | CNT_W | Terminal count of the hook filter |
| gndKeyLimit | input | CNT_W | Terminal count of the ground-key filter |
| hookStatN | output | 1 | Hook / ring-trip status, 0 = off hook or ground key |
| gndKeyStatN | output | 1 | Ground-key status, 0 = ground key present |
| codecPuN | output | 1 | Codec power-up, 0 = codec enabled |
| ringEn | output | 1 | Ringing injector enable, 1 = inject |

## Verification
The hardest state to reach is the latched ring trip with the detection already gone. Ringing must be entered first, the hook raw bit held for at least the terminal count, and then released and allowed to count fully back to zero, while the ring request stays high the whole time. The vector table moves through that sequence in order, so each step starts from the state the previous one left. Directed tests cover the rest. They time the debounce edges cycle by cycle with a short glitch and with held levels, and they check that stand-by clears a filter that had already tripped, so the full count is needed again on exit.

// File: rtl/lmc_pkg.sv
package lmc_pkg;

  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'd0,
    MODE_RING   = 2'd1,
    MODE_STBY   = 2'd2
  } lineMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic filtClr;
  } lmcStrobe_t;

  localparam int NUM_DET = 2;
  localparam int DET_HOOK = 0;
  localparam int DET_GK   = 1;

endpackage

// File: rtl/lmc_filter.sv
module lmc_filter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             rawIn,
  input  logic [CNT_W-1:0] limit,
  output logic             detOut
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;
  logic             detNext;

  always_comb begin
    cntNext = cnt;
    if (clr) begin
      cntNext = '0;
    end else if (rawIn) begin
      cntNext = (cnt >= limit) ? limit : cnt + 1'b1;
    end else if (cnt != '0) begin
      cntNext = cnt - 1'b1;
    end
  end

  always_comb begin
    detNext = detOut;
    if (clr) begin
      detNext = 1'b0;
    end else if (rawIn && (cntNext == limit)) begin
      detNext = 1'b1;
    end else if (!rawIn && (cntNext == '0)) begin
      detNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      detOut <= 1'b0;
    end else begin
      cnt    <= cntNext;
      detOut <= detNext;
    end
  end

  // R9: filtered bit only sets while the raw bit was high
  a_r9_rise_needs_raw : assert property (@(posedge clk) disable iff (!rstN)
    $rose(detOut) |-> $past(rawIn));

  // R9: filtered bit only clears on a low raw bit or a clear strobe
  a_r9_fall_needs_low : assert property (@(posedge clk) disable iff (!rstN)
    $fell(detOut) |-> ($past(!rawIn) || $past(clr)));

  // R11: a clear strobe leaves no detection behind
  a_r11_clear_empties : assert property (@(posedge clk) disable iff (!rstN)
    clr |=> !detOut);

endmodule

// File: rtl/lmc_datapath.sv
module lmc_datapath
  import lmc_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  lmcStrobe_t           strobe,
  input  logic                 standbyIn,
  input  logic                 ringReqIn,
  input  logic [NUM_DET-1:0]   rawDet,
  input  logic [CNT_W-1:0]     limitHook,
  input  logic [CNT_W-1:0]     limitGk,
  output logic                 syncStandby,
  output logic                 syncRing,
  output logic [NUM_DET-1:0]   filtDet
);

  logic [SYNC_N-1:0] stbyPipe;
  logic [SYNC_N-1:0] ringPipe;
  logic [CNT_W-1:0]  limitVec [NUM_DET];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbyPipe <= '0;
      ringPipe <= '0;
    end else begin
      stbyPipe <= {stbyPipe[SYNC_N-2:0], standbyIn};
      ringPipe <= {ringPipe[SYNC_N-2:0], ringReqIn};
    end
  end

  assign syncStandby = stbyPipe[SYNC_N-1];
  assign syncRing    = ringPipe[SYNC_N-1];

  assign limitVec[DET_HOOK] = limitHook;
  assign limitVec[DET_GK]   = limitGk;

  for (genvar d = 0; d < NUM_DET; d++) begin : g_det
    lmc_filter #(.CNT_W(CNT_W)) u_filt (
      .clk    (clk),
      .rstN   (rstN),
      .clr    (strobe.filtClr),
      .rawIn  (rawDet[d]),
      .limit  (limitVec[d]),
      .detOut (filtDet[d])
    );
  end

endmodule

// File: rtl/lmc_control.sv
module lmc_control
  import lmc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               syncStandby,
  input  logic               syncRing,
  input  logic [NUM_DET-1:0] filtDet,
  output lmcStrobe_t         strobe,
  output logic               hookStatN,
  output logic               gndKeyStatN,
  output logic               codecPuN,
  output logic               ringEn
);

  lineMode_t mode;
  logic      tripLatch;
  logic      tripNext;
  logic      anyDet;
  logic      hookNext;
  logic      gkNext;
  logic      puNext;
  logic      enNext;

  always_comb begin
    if (syncStandby)   mode = MODE_STBY;
    else if (syncRing) mode = MODE_RING;
    else               mode = MODE_ACTIVE;
  end

  assign strobe.filtClr = (mode == MODE_STBY);
  assign anyDet = |filtDet;

  always_comb begin
    tripNext = tripLatch;
    if (!syncRing)                          tripNext = 1'b0;
    else if (mode == MODE_RING && anyDet)   tripNext = 1'b1;
  end

  always_comb begin
    hookNext = 1'b1;
    gkNext   = 1'b1;
    puNext   = 1'b1;
    enNext   = 1'b0;
    unique case (mode)
      MODE_ACTIVE: begin
        hookNext = !anyDet;
        gkNext   = !filtDet[DET_GK];
        puNext   = !anyDet;
      end
      MODE_RING: begin
        hookNext = !anyDet;
        gkNext   = !filtDet[DET_GK];
        puNext   = 1'b0;
        enNext   = !tripNext;
      end
      MODE_STBY: begin
        puNext = !syncRing;
        enNext = syncRing;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tripLatch   <= 1'b0;
      hookStatN   <= 1'b1;
      gndKeyStatN <= 1'b1;
      codecPuN    <= 1'b1;
      ringEn      <= 1'b0;
    end else begin
      tripLatch   <= tripNext;
      hookStatN   <= hookNext;
      gndKeyStatN <= gkNext;
      codecPuN    <= puNext;
      ringEn      <= enNext;
    end
  end

  // R7: a reported detection never coexists with injection
  a_r7_trip_blocks_enable : assert property (@(posedge clk) disable iff (!rstN)
    !hookStatN |-> !ringEn);

  // R5: ground key status implies hook status
  a_r5_gk_pulls_hook : assert property (@(posedge clk) disable iff (!rstN)
    !gndKeyStatN |-> !hookStatN);

  // R6: injection always comes with the codec powered
  a_r6_enable_powers_codec : assert property (@(posedge clk) disable iff (!rstN)
    ringEn |-> !codecPuN);

  // R7: latch holds while ring request stays high
  a_r7_latch_holds : assert property (@(posedge clk) disable iff (!rstN)
    (tripLatch && syncRing) |=> tripLatch);

endmodule

// File: rtl/line_mode_ctrl.sv
module line_mode_ctrl
  import lmc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             standbyIn,
  input  logic             ringReqIn,
  input  logic             hookRaw,
  input  logic             gndKeyRaw,
  input  logic [CNT_W-1:0] hookLimit,
  input  logic [CNT_W-1:0] gndKeyLimit,
  output logic             hookStatN,
  output logic             gndKeyStatN,
  output logic             codecPuN,
  output logic             ringEn
);

  lmcStrobe_t         strobe;
  logic               syncStandby;
  logic               syncRing;
  logic [NUM_DET-1:0] filtDet;
  logic [NUM_DET-1:0] rawDet;

  assign rawDet[DET_HOOK] = hookRaw;
  assign rawDet[DET_GK]   = gndKeyRaw;

  lmc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .standbyIn   (standbyIn),
    .ringReqIn   (ringReqIn),
    .rawDet      (rawDet),
    .limitHook   (hookLimit),
    .limitGk     (gndKeyLimit),
    .syncStandby (syncStandby),
    .syncRing    (syncRing),
    .filtDet     (filtDet)
  );

  lmc_control u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .syncStandby (syncStandby),
    .syncRing    (syncRing),
    .filtDet     (filtDet),
    .strobe      (strobe),
    .hookStatN   (hookStatN),
    .gndKeyStatN (gndKeyStatN),
    .codecPuN    (codecPuN),
    .ringEn      (ringEn)
  );

endmodule

// File: tb/sim_line_mode_ctrl.sv
`timescale 1ns/1ps
module sim_line_mode_ctrl;

  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic standbyIn = 1'b0;
  logic ringReqIn = 1'b0;
  logic hookRaw = 1'b0;
  logic gndKeyRaw = 1'b0;
  logic [CNT_W-1:0] hookLimit = 8'd3;
  logic [CNT_W-1:0] gndKeyLimit = 8'd5;
  logic hookStatN, gndKeyStatN, codecPuN, ringEn;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  line_mode_ctrl #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .standbyIn(standbyIn), .ringReqIn(ringReqIn),
    .hookRaw(hookRaw), .gndKeyRaw(gndKeyRaw), .hookLimit(hookLimit),
    .gndKeyLimit(gndKeyLimit), .hookStatN(hookStatN), .gndKeyStatN(gndKeyStatN),
    .codecPuN(codecPuN), .ringEn(ringEn)
  );

  // {standby, ring, hook, gk, exp hookN, exp gkN, exp puN, exp en}
  localparam int NVEC = 14;
  localparam logic [7:0] VEC [NVEC] = '{
    8'b0000_1110, 8'b0010_0100, 8'b0001_0000, 8'b0011_0000,
    8'b0000_1110, 8'b0100_1101, 8'b0110_0100, 8'b0100_1100,
    8'b0000_1110, 8'b0100_1101, 8'b0101_0000, 8'b1011_1110,
    8'b1111_1101, 8'b0000_1110
  };

  function automatic string vecTag(int i);
    case (i)
      0, 4, 8, 13: return "R3";
      1:           return "R4";
      2, 3, 10:    return "R5";
      5, 9:        return "R6";
      6, 7:        return "R7";
      default:     return "R8";
    endcase
  endfunction

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(logic [3:0] exp, string tag);
    logic [3:0] got;
    got = {hookStatN, gndKeyStatN, codecPuN, ringEn};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: outputs actual=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    // R1: reset state
    step(3);
    check(4'b1110, "R1");
    rstN = 1'b1;
    step(4);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      {standbyIn, ringReqIn, hookRaw, gndKeyRaw} = VEC[i][7:4];
      step(12);
      check(VEC[i][3:0], vecTag(i));
    end

    // R2: mode latency of three edges
    ringReqIn = 1'b1;
    step(2);
    check(4'b1110, "R2");
    step(1);
    check(4'b1101, "R2");
    ringReqIn = 1'b0;
    step(8);

    // R9: short glitch ignored
    hookRaw = 1'b1;
    step(2);
    hookRaw = 1'b0;
    step(8);
    check(4'b1110, "R9");

    // R9: held level reported one edge after terminal count
    hookRaw = 1'b1;
    step(3);
    check(4'b1110, "R9");
    step(1);
    check(4'b0100, "R9");
    hookRaw = 1'b0;
    step(3);
    check(4'b0100, "R9");
    step(1);
    check(4'b1110, "R9");

    // R10: ground-key filter uses its own terminal count (5)
    gndKeyRaw = 1'b1;
    step(5);
    check(4'b1110, "R10");
    step(1);
    check(4'b0000, "R10");
    gndKeyRaw = 1'b0;
    step(10);
    check(4'b1110, "R10");

    // R11: stand-by clears a tripped filter
    hookRaw = 1'b1;
    step(6);
    check(4'b0100, "R11");
    standbyIn = 1'b1;
    step(6);
    check(4'b1110, "R11");
    standbyIn = 1'b0;
    step(5);
    check(4'b1110, "R11");
    step(1);
    check(4'b0100, "R11");
    hookRaw = 1'b0;
    step(8);

    // R1: reset mid-ring clears the trip latch
    ringReqIn = 1'b1;
    hookRaw = 1'b1;
    step(10);
    check(4'b0100, "R7");
    rstN = 1'b0;
    step(1);
    check(4'b1110, "R1");
    hookRaw = 1'b0;
    rstN = 1'b1;
    step(10);
    check(4'b1101, "R1");

    summary();
  end

endmodule